// File: doc/BRIEF.md
# Front-End Fast-Command Receiver

This block sits at the front end of a detector readout channel and takes in one 24-bit fast-control word on every bunch-crossing clock. It splits the word into a bunch identifier and seven single-bit commands. Each command runs through its own shift-register delay before it acts, so every command can be aligned to the front-end pipeline on its own.

The delayed commands drive single-cycle strobes for the bunch-counter reset, the event-counter reset, the calibration pulse and the non-zero-suppressed readout. Downstream counters of accepted crossings, truncated events and received commands clear on the event-counter-reset strobe. A front-end reset produces a level that lasts a programmed number of crossings. A header-only flag tells the data formatter to send only the event header. Four sources raise that flag: the explicit command, a crossing veto, the crossings that follow a non-zero-suppressed readout, and the whole front-end reset window.

A local bunch counter is reloaded by the delayed bunch-counter reset and wraps at a programmable orbit length. It is compared with the received bunch identifier on every crossing. Delays, window lengths and the orbit length are set through a simple write port.

Top module: `fe_fastcmd_rx`

## Requirements
- R1: Word layout: bits [11:0] carry the bunch ID. The command bits are: bit 12 bunch-counter reset, bit 13 event-counter reset, bit 14 header-only, bit 15 calibration, bit 16 non-zero-suppressed readout, bit 17 crossing veto, bit 18 front-end reset. Bits [23:19] are reserved and have no effect on any output.
- R2: A command bit sampled at clock edge t acts on the outputs registered at edge t+d, where d (0 to 15) is that command's delay. Delays are written at config address k for the command at word bit 12+k, k = 0..6.
- R3: A delayed bunch-counter reset loads the local bunch counter with zero. It also raises `bcr_o` for one cycle.
- R4: The local bunch counter counts up by one each cycle and goes from orbit_len-1 back to 0. orbit_len is at config address 10 and defaults to 3564.
- R5: `bx_mismatch_o`, registered at edge t, is high exactly when the bunch ID sampled at edge t differs from the local counter value held before edge t.
- R6: A delayed event-counter reset raises `ecr_o` for one cycle. A delayed calibration command raises `cal_o` for one cycle.
- R7: A delayed header-only command raises `hdr_only_o` for that one crossing.
- R8: A delayed non-zero-suppressed readout raises `nzs_o` for one cycle without raising `hdr_only_o` on account of the readout. The next n cycles then have `hdr_only_o` high. n is at config address 8 and defaults to 3.
- R9: A delayed crossing veto raises `hdr_only_o` for that crossing.
- R10: A delayed front-end reset holds `fer_o` high for L cycles, starting on the edge that applies the command, and `hdr_only_o` is high whenever `fer_o` is high. L is at config address 9 and defaults to 4. L = 0 gives no pulse.
- R11: Writes to config addresses other than 0..6 and 8..10 have no effect.
- R12: After reset all strobes, `fer_o`, `hdr_only_o` and `bx_mismatch_o` are low, the local counter is 0 and all delays are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_word | input | 24 | Fast-control word for this crossing |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Config register address |
| cfg_wdata | input | 16 | Config write data |
| bcr_o | output | 1 | Bunch-counter reset strobe |
| ecr_o | output | 1 | Event-counter reset strobe |
| cal_o | output | 1 | Calibration pulse strobe |
| nzs_o | output | 1 | Non-zero-suppressed readout strobe |
| fer_o | output | 1 | Front-end reset level |
| hdr_only_o | output | 1 | Send header only for this crossing |
| bx_mismatch_o | output | 1 | Received bunch ID differs from the local counter |
| local_bx_o | output | 12 | Local bunch counter |

## Verification
The assertions check four things on every cycle. A veto or the front-end reset level always brings the header-only flag with it. The crossing after a readout strobe with nonzero n is header-only. The counter lands on zero after a bunch-counter reset or at the orbit end, and the mismatch flag follows the sampled ID against the local count. Other behaviour can only be shown by the bench scenarios: the exact cycle each delayed command lands on, the full length of the readout and reset windows, and wrap at the default orbit length. The same holds for the reserved bits and unmapped config addresses having no effect.

// File: rtl/fc_rx_pkg.sv
package fc_rx_pkg;
    localparam int NUM_CMD = 7;

    // Command index k lives at word bit (bunch-ID width + k)
    typedef enum int {
        CMD_BCR  = 0,
        CMD_ECR  = 1,
        CMD_HDR  = 2,
        CMD_CAL  = 3,
        CMD_NZS  = 4,
        CMD_VETO = 5,
        CMD_FER  = 6
    } cmd_idx_e;

    localparam int CFG_NZS_LEN = 8;
    localparam int CFG_FER_LEN = 9;
    localparam int CFG_ORBIT   = 10;
endpackage

// File: rtl/fc_delay_line.sv
module fc_delay_line #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [DLY_W-1:0] dly,
    output logic             dout
);
    localparam int TAPS = (1 << DLY_W) - 1;

    logic [TAPS-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[TAPS-2:0], din};
        if (dly == '0) dout = din;
        else           dout = sr_q[dly - DLY_W'(1)];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end
endmodule

// File: rtl/fc_bx_tracker.sv
module fc_bx_tracker #(
    parameter int BID_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bcr,
    input  logic [BID_W-1:0] orbit_len,
    input  logic [BID_W-1:0] bid_rx,
    output logic [BID_W-1:0] bx_o,
    output logic             mismatch_o
);
    typedef struct packed {
        logic [BID_W-1:0] bx;
        logic             mis;
    } bx_state_t;

    bx_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.mis = (bid_rx != s_q.bx);
        if (bcr)                                   s_d.bx = '0;
        else if (s_q.bx >= orbit_len - BID_W'(1))  s_d.bx = '0;
        else                                       s_d.bx = s_q.bx + BID_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bx_o       = s_q.bx;
    assign mismatch_o = s_q.mis;
endmodule

// File: rtl/fe_fastcmd_rx.sv
module fe_fastcmd_rx
    import fc_rx_pkg::*;
#(
    parameter int CMD_W     = 24,
    parameter int BID_W     = 12,
    parameter int DLY_W     = 4,
    parameter int CNT_W     = 8,
    parameter int CFG_AW    = 4,
    parameter int CFG_DW    = 16,
    parameter int ORBIT_DEF = 3564,
    parameter int NZS_DEF   = 3,
    parameter int FER_DEF   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              bcr_o,
    output logic              ecr_o,
    output logic              cal_o,
    output logic              nzs_o,
    output logic              fer_o,
    output logic              hdr_only_o,
    output logic              bx_mismatch_o,
    output logic [BID_W-1:0]  local_bx_o
);
    localparam int CMD_LSB = BID_W;
    localparam int CMD_IW  = $clog2(NUM_CMD);

    typedef struct packed {
        logic [NUM_CMD-1:0][DLY_W-1:0] dly;
        logic [CNT_W-1:0]              nzs_len;
        logic [CNT_W-1:0]              fer_len;
        logic [BID_W-1:0]              orbit;
        logic [CNT_W-1:0]              nzs_left;
        logic [CNT_W-1:0]              fer_left;
        logic                          bcr;
        logic                          ecr;
        logic                          cal;
        logic                          nzs;
        logic                          fer;
        logic                          hdr;
    } rx_state_t;

    rx_state_t          s_d, s_q;
    logic [NUM_CMD-1:0] tap;
    logic               unused_bits;

    // Per-command delay lines
    for (genvar k = 0; k < NUM_CMD; k++) begin : g_dly
        fc_delay_line #(.DLY_W(DLY_W)) u_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cmd_word[CMD_LSB+k]),
            .dly  (s_q.dly[k]),
            .dout (tap[k])
        );
    end

    // Names the checker binds to
    logic             tap_bcr_w, tap_veto_w;
    logic [CNT_W-1:0] nzs_len_w;
    logic [BID_W-1:0] orbit_w;
    assign tap_bcr_w  = tap[CMD_BCR];
    assign tap_veto_w = tap[CMD_VETO];
    assign nzs_len_w  = s_q.nzs_len;
    assign orbit_w    = s_q.orbit;

    fc_bx_tracker #(.BID_W(BID_W)) u_bx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bcr       (tap[CMD_BCR]),
        .orbit_len (s_q.orbit),
        .bid_rx    (cmd_word[BID_W-1:0]),
        .bx_o      (local_bx_o),
        .mismatch_o(bx_mismatch_o)
    );

    // Reserved word bits and spare config bits are read nowhere else
    assign unused_bits = ^{cmd_word, cfg_wdata};

    always_comb begin
        s_d = s_q;

        if (cfg_we) begin
            if (int'(cfg_addr) < NUM_CMD)
                s_d.dly[cfg_addr[CMD_IW-1:0]] = cfg_wdata[DLY_W-1:0];
            else if (int'(cfg_addr) == CFG_NZS_LEN)
                s_d.nzs_len = cfg_wdata[CNT_W-1:0];
            else if (int'(cfg_addr) == CFG_FER_LEN)
                s_d.fer_len = cfg_wdata[CNT_W-1:0];
            else if (int'(cfg_addr) == CFG_ORBIT)
                s_d.orbit = cfg_wdata[BID_W-1:0];
        end

        s_d.bcr = tap[CMD_BCR];
        s_d.ecr = tap[CMD_ECR];
        s_d.cal = tap[CMD_CAL];
        s_d.nzs = tap[CMD_NZS];

        // Header-only window after a full readout
        if (tap[CMD_NZS])               s_d.nzs_left = s_q.nzs_len;
        else if (s_q.nzs_left != '0)    s_d.nzs_left = s_q.nzs_left - CNT_W'(1);

        // Front-end reset window
        if (tap[CMD_FER]) begin
            s_d.fer_left = s_q.fer_len;
            s_d.fer      = (s_q.fer_len != '0);
        end else begin
            s_d.fer = (s_q.fer_left > CNT_W'(1));
            if (s_q.fer_left != '0) s_d.fer_left = s_q.fer_left - CNT_W'(1);
        end

        s_d.hdr = tap[CMD_HDR] | tap[CMD_VETO] | s_d.fer
                | (!tap[CMD_NZS] && (s_q.nzs_left != '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.nzs_len <= CNT_W'(NZS_DEF);
            s_q.fer_len <= CNT_W'(FER_DEF);
            s_q.orbit   <= BID_W'(ORBIT_DEF);
        end else begin
            s_q <= s_d;
        end
    end

    assign bcr_o      = s_q.bcr;
    assign ecr_o      = s_q.ecr;
    assign cal_o      = s_q.cal;
    assign nzs_o      = s_q.nzs;
    assign fer_o      = s_q.fer;
    assign hdr_only_o = s_q.hdr;
endmodule

// File: rtl/fc_rx_checker.sv
module fc_rx_checker #(
    parameter int BID_W = 12,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tap_bcr,
    input logic             tap_veto,
    input logic             nzs_o,
    input logic [CNT_W-1:0] nzs_len,
    input logic             fer_o,
    input logic             hdr_only_o,
    input logic [BID_W-1:0] local_bx_o,
    input logic [BID_W-1:0] orbit_len,
    input logic [BID_W-1:0] bid_rx,
    input logic             bx_mismatch_o
);
    AST_VETO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        tap_veto |=> hdr_only_o);  // R9

    AST_FER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        fer_o |-> hdr_only_o);  // R10

    AST_NZS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (nzs_o && nzs_len != '0) |=> hdr_only_o);  // R8

    AST_BCR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tap_bcr |=> (local_bx_o == '0));  // R3

    AST_BX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (local_bx_o >= orbit_len - BID_W'(1)) |=> (local_bx_o == '0));  // R4

    AST_BX_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bx_mismatch_o == ($past(bid_rx) != $past(local_bx_o))));  // R5
endmodule

bind fe_fastcmd_rx fc_rx_checker #(.BID_W(BID_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tap_bcr      (tap_bcr_w),
    .tap_veto     (tap_veto_w),
    .nzs_o        (nzs_o),
    .nzs_len      (nzs_len_w),
    .fer_o        (fer_o),
    .hdr_only_o   (hdr_only_o),
    .local_bx_o   (local_bx_o),
    .orbit_len    (orbit_w),
    .bid_rx       (cmd_word[BID_W-1:0]),
    .bx_mismatch_o(bx_mismatch_o)
);

// File: tb/fe_fastcmd_rx_tb.sv
module fe_fastcmd_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cmd_word = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bcr_o, ecr_o, cal_o, nzs_o, fer_o, hdr_only_o, bx_mismatch_o;
    logic [11:0] local_bx_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fe_fastcmd_rx u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .bcr_o(bcr_o), .ecr_o(ecr_o), .cal_o(cal_o), .nzs_o(nzs_o),
        .fer_o(fer_o), .hdr_only_o(hdr_only_o),
        .bx_mismatch_o(bx_mismatch_o), .local_bx_o(local_bx_o)
    );

    // Command indices: 0 bcr, 1 ecr, 2 hdr, 3 cal, 4 nzs, 5 veto, 6 fer (word bit 12+k)
    function automatic logic [23:0] mk(input logic [11:0] bid, input int cmd);
        logic [23:0] w;
        w = {12'h000, bid};
        if (cmd >= 0) w[12+cmd] = 1'b1;
        return w;
    endfunction

    function automatic logic out_of(input int cmd);
        case (cmd)
            0:       return bcr_o;
            1:       return ecr_o;
            3:       return cal_o;
            4:       return nzs_o;
            6:       return fer_o;
            default: return hdr_only_o;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        cmd_word = '0;
        repeat (n) @(negedge clk);
    endtask

    // Send one command and check that it lands exactly d cycles later
    task automatic t_delay(input string req, input int cmd, input int d, input bit do_cfg);
        if (do_cfg) cfg_wr(cmd, d);
        cmd_word = mk(12'h0, cmd);
        @(negedge clk);
        cmd_word = '0;
        for (int i = 0; i < d; i++) begin
            chk({req, " early"}, int'(out_of(cmd)), 0);
            @(negedge clk);
        end
        chk({req, " on time"}, int'(out_of(cmd)), 1);
        @(negedge clk);
        chk({req, " after"}, int'(out_of(cmd)), 0);
        idle(6);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R12 strobes", int'({bcr_o, ecr_o, cal_o, nzs_o}), 0);
        chk("R12 fer/hdr/mis", int'({fer_o, hdr_only_o, bx_mismatch_o}), 0);
        chk("R12 local_bx", int'(local_bx_o), 0);
    endtask

    task automatic t_default_orbit();
        cmd_word = mk(12'h0, 0);
        @(negedge clk);
        cmd_word = '0;
        chk("R3 bx zero after bcr", int'(local_bx_o), 0);
        repeat (3563) @(negedge clk);
        chk("R4 default orbit end", int'(local_bx_o), 3563);
        @(negedge clk);
        chk("R4 default orbit wrap", int'(local_bx_o), 0);
    endtask

    task automatic t_short_orbit();
        cfg_wr(10, 5);
        cmd_word = mk(12'h0, 0);
        @(negedge clk);
        cmd_word = '0;
        chk("R3 bx zero", int'(local_bx_o), 0);
        repeat (4) @(negedge clk);
        chk("R4 orbit5 top", int'(local_bx_o), 4);
        @(negedge clk);
        chk("R4 orbit5 wrap", int'(local_bx_o), 0);
    endtask

    task automatic t_mismatch();
        cmd_word = mk(12'h0, 0);
        @(negedge clk);
        cmd_word = mk(12'd0, -1);
        @(negedge clk);
        chk("R5 match bx0", int'(bx_mismatch_o), 0);
        cmd_word = mk(12'd1, -1);
        @(negedge clk);
        chk("R5 match bx1", int'(bx_mismatch_o), 0);
        cmd_word = mk(12'd7, -1);
        @(negedge clk);
        chk("R5 mismatch bx2", int'(bx_mismatch_o), 1);
        cmd_word = mk(12'd3, -1);
        @(negedge clk);
        chk("R5 match bx3", int'(bx_mismatch_o), 0);
        idle(4);
    endtask

    task automatic t_nzs();
        cfg_wr(8, 2);
        cmd_word = mk(12'h0, 4);
        @(negedge clk);
        cmd_word = '0;
        chk("R8 nzs strobe", int'(nzs_o), 1);
        chk("R8 nzs crossing not hdr", int'(hdr_only_o), 0);
        @(negedge clk);
        chk("R8 window 1", int'(hdr_only_o), 1);
        chk("R8 strobe single", int'(nzs_o), 0);
        @(negedge clk);
        chk("R8 window 2", int'(hdr_only_o), 1);
        @(negedge clk);
        chk("R8 window end", int'(hdr_only_o), 0);
        idle(4);
    endtask

    task automatic t_fer(input int len);
        cfg_wr(9, len);
        cmd_word = mk(12'h0, 6);
        @(negedge clk);
        cmd_word = '0;
        for (int i = 0; i < len; i++) begin
            chk("R10 fer level", int'(fer_o), 1);
            chk("R10 hdr during fer", int'(hdr_only_o), 1);
            @(negedge clk);
        end
        chk("R10 fer end", int'(fer_o), 0);
        chk("R10 hdr end", int'(hdr_only_o), 0);
        idle(4);
    endtask

    task automatic t_reserved();
        cmd_word = 24'hF8_0000;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk("R1 reserved strobes", int'({bcr_o, ecr_o, cal_o, nzs_o}), 0);
            chk("R1 reserved fer/hdr", int'({fer_o, hdr_only_o}), 0);
            @(negedge clk);
        end
        idle(2);
    endtask

    initial begin
        t_reset();
        t_default_orbit();
        t_delay("R6 ecr d0", 1, 0, 1'b1);
        t_delay("R2 R6 cal d15", 3, 15, 1'b1);
        t_delay("R2 R7 hdr d3", 2, 3, 1'b1);
        t_delay("R2 R9 veto d2", 5, 2, 1'b1);
        t_delay("R2 R3 bcr d7", 0, 7, 1'b1);
        cfg_wr(0, 0);
        cfg_wr(7, 0);
        cfg_wr(15, 0);
        cfg_wr(11, 0);
        t_delay("R11 cal delay kept", 3, 15, 1'b0);
        t_short_orbit();
        t_mismatch();
        t_nzs();
        t_fer(3);
        t_fer(0);
        t_reserved();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule